// File: doc/BRIEF.md
# Key-Locked System Configuration Register Bank

This block is a bank of 32-bit configuration registers in a 4 KB window. A single-cycle register bus reaches it, and the bus addresses it by word. Each cycle carries at most one access: a select, a write enable, a 10-bit word address and the write data. Read data is registered and appears on the cycle after the read.

A few words at the bottom of the window can always be reached:
- a one-bit control word,
- a lock word,
- an unlock word,
- a lock-status word.

Every other configuration word accepts writes only while the bank is unlocked. Software unlocks the bank by writing a 16-bit key to the unlock word, and it relocks the bank by writing a different key to the lock word.

There are four mapped ranges:
- a clock-generator range, with a read-only status word,
- a reset-control range, with a read-only word and a word that always reads 1,
- a memory-interface range, with a hole,
- 54 pin-configuration words.

All other addresses read as zero and ignore writes. The contents of every mapped word are brought out as flat output vectors.

Top module: `syscfg_regbank`

## Requirements
- R1: A write to byte offset 0x004 (word 1) whose wdata[15:0] equals 0x767B makes the bank locked. Any other value written there leaves the lock state unchanged.
- R2: A write to byte offset 0x008 (word 2) whose wdata[15:0] equals 0xDF0D makes the bank unlocked, whatever bits 31:16 hold. Any other value leaves the lock state unchanged.
- R3: After reset the bank is locked. A read of byte offset 0x00C returns 1 in bit 0 when locked and 0 when unlocked. Writes to 0x00C have no effect.
- R4: Reads of byte offsets 0x004 and 0x008 always return zero.
- R5: Byte offset 0x000 stores wdata[0] only and reads back as {31'b0, bit}. It is writable whether the bank is locked or not, and it resets to 0.
- R6: While the bank is locked, a write to any offset above 0x00C leaves every register unchanged.
- R7: Clock-generator words at 0x100–0x11C reset as follows: words 0–2 to 0x0001A008, word 3 (0x10C) to 0x0000003F, words 4–6 to 0x00014000, and word 7 to 0. Word 3 is read-only even when the bank is unlocked. The other words in this range are writable.
- R8: Reset-control words at 0x200–0x25C reset to 0. Offset 0x250 is read-only, and 0x25C always reads 1. The other words in this range are writable.
- R9: Memory-interface words at 0x600–0x620 reset to 0 and are writable, except 0x604, which reads zero and ignores writes.
- R10: The 54 pin-configuration words at 0x700–0x7D4 are writable. They reset to 0x00001601, except words 2 through 8, which reset to 0x00000601.
- R11: Reads of any other offset return zero, and writes to them change nothing.
- R12: rdata takes the read value on the cycle after a read. It holds that value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Access strobe for this cycle |
| we | input | 1 | 1 = write, 0 = read (with sel) |
| addr | input | 10 | Word address (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ctrl_bit | output | 1 | Content of the control word |
| locked | output | 1 | Lock state |
| pll_q | output | 256 | Clock-generator words, word 0 in bits 31:0 |
| rstctl_q | output | 768 | Reset-control words, word 0 in bits 31:0 |
| ddr_q | output | 288 | Memory-interface words, word 0 in bits 31:0 |
| pin_q | output | 1728 | Pin-configuration words, word 0 in bits 31:0 |

## Verification
The assertions assume one access per cycle: sel qualifies we, so a read and a write never occur together. They also assume the bus inputs are settled at each rising edge. The bench drives every access from a task on the falling edge and holds sel for exactly one cycle before releasing it. It leaves idle cycles between bursts, so that the hold of rdata and the lock state is also observed while nothing happens on the bus.

// File: rtl/syscfg_pkg.sv
// Shared constants, region kinds and per-word attributes of the register bank.
// Assumes word addressing (byte offset / 4) and 32-bit reset images.
package syscfg_pkg;

    localparam int W_CTRL   = 0;
    localparam int W_LOCK   = 1;
    localparam int W_UNLOCK = 2;
    localparam int W_STATUS = 3;

    localparam logic [15:0] KEY_LOCK   = 16'h767B;
    localparam logic [15:0] KEY_UNLOCK = 16'hDF0D;

    localparam int PLL_BASE = 'h040;
    localparam int PLL_N    = 8;
    localparam int RST_BASE = 'h080;
    localparam int RST_N    = 24;
    localparam int DDR_BASE = 'h180;
    localparam int DDR_N    = 9;
    localparam int PIN_BASE = 'h1C0;
    localparam int PIN_N    = 54;

    typedef enum logic [1:0] {RGN_PLL, RGN_RST, RGN_DDR, RGN_PIN} rgn_e;

    typedef struct packed {
        logic        writable;
        logic [31:0] init;
    } word_attr_t;

    // Writability and reset image of word idx inside region k.
    function automatic word_attr_t word_attr(rgn_e k, int idx);
        word_attr_t a;
        a.writable = 1'b1;
        a.init     = 32'h0;
        case (k)
            RGN_PLL: begin
                if (idx <= 2)      a.init = 32'h0001A008;
                else if (idx == 3) begin a.init = 32'h0000003F; a.writable = 1'b0; end
                else if (idx <= 6) a.init = 32'h00014000;
            end
            RGN_RST: begin
                if (idx == 20) a.writable = 1'b0;
                if (idx == 23) begin a.writable = 1'b0; a.init = 32'h1; end
            end
            RGN_DDR: begin
                if (idx == 1) a.writable = 1'b0;
            end
            default: begin
                a.init = (idx >= 2 && idx <= 8) ? 32'h00000601 : 32'h00001601;
            end
        endcase
        return a;
    endfunction

endpackage

// File: rtl/syscfg_keylock.sv
// Always-reachable words: the control bit and the key-driven lock state.
// Assumes at most one access per cycle; bus_wr is already qualified by select.
module syscfg_keylock
    import syscfg_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wkey,
    output logic              locked,
    output logic              ctrl_bit
);

    logic hit_lock, hit_unlock, hit_ctrl;

    assign hit_lock   = bus_wr && (addr == ADDR_W'(W_LOCK));
    assign hit_unlock = bus_wr && (addr == ADDR_W'(W_UNLOCK));
    assign hit_ctrl   = bus_wr && (addr == ADDR_W'(W_CTRL));

    // Lock state: set by the lock key, cleared by the unlock key, locked at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                              locked <= 1'b1;
        else if (hit_lock && wkey == KEY_LOCK)     locked <= 1'b1;
        else if (hit_unlock && wkey == KEY_UNLOCK) locked <= 1'b0;
    end

    // Control bit: keeps bit 0 of any write to word 0, regardless of lock.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_bit <= 1'b0;
        else if (hit_ctrl) ctrl_bit <= wkey[0];
    end

    AST_LOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_lock && wkey == KEY_LOCK) |=> locked); // R1
    AST_UNLOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_unlock && wkey == KEY_UNLOCK) |=> !locked); // R2
    AST_LOCK_ONLY_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        (locked != $past(locked)) |-> $past(hit_lock || hit_unlock)); // R1
    AST_CTRL_ANY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl |=> (ctrl_bit == $past(wkey[0]))); // R5

endmodule

// File: rtl/syscfg_region.sv
// One contiguous range of configuration words. Each word is a register or a
// constant, as the package attribute function decides. wr_en must already
// include the unlock condition. The read word is valid only while hit is high.
module syscfg_region
    import syscfg_pkg::*;
#(
    parameter rgn_e KIND   = RGN_PLL,
    parameter int   BASE   = 0,
    parameter int   COUNT  = 1,
    parameter int   ADDR_W = 10,
    parameter int   DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [COUNT*DATA_W-1:0] q,
    output logic                    hit,
    output logic [DATA_W-1:0]       rd_word
);

    localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(BASE + COUNT - 1);

    logic [ADDR_W-1:0] off;

    assign hit = (addr >= FIRST) && (addr <= LAST);
    assign off = addr - FIRST;

    for (genvar i = 0; i < COUNT; i++) begin : g_word
        localparam word_attr_t ATTR = word_attr(KIND, i);
        if (ATTR.writable) begin : g_rw
            logic [DATA_W-1:0] r;
            // Stored word: reset image, then the last unlocked write.
            always_ff @(posedge clk) begin
                if (!rst_n)                                    r <= DATA_W'(ATTR.init);
                else if (wr_en && hit && off == ADDR_W'(i))    r <= wdata;
            end
            assign q[i*DATA_W +: DATA_W] = r;
        end else begin : g_ro
            assign q[i*DATA_W +: DATA_W] = DATA_W'(ATTR.init);
        end
    end

    // Read selection of the addressed word within the range.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < COUNT; i++) begin
            if (off == ADDR_W'(i)) rd_word = q[i*DATA_W +: DATA_W];
        end
    end

    AST_RGN_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit) |=> $stable(q)); // R6

endmodule

// File: rtl/syscfg_regbank.sv
// Top of the key-locked register bank. It decodes the single-cycle bus,
// gates configuration writes with the lock state and registers read data.
// Assumes one access per cycle, qualified by sel.
module syscfg_regbank
    import syscfg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic                    ctrl_bit,
    output logic                    locked,
    output logic [PLL_N*DATA_W-1:0] pll_q,
    output logic [RST_N*DATA_W-1:0] rstctl_q,
    output logic [DDR_N*DATA_W-1:0] ddr_q,
    output logic [PIN_N*DATA_W-1:0] pin_q
);

    logic bus_wr, bus_rd, cfg_wr;
    logic pll_hit, rst_hit, ddr_hit, pin_hit;
    logic [DATA_W-1:0] pll_rd, rst_rd, ddr_rd, pin_rd, rd_next;

    assign bus_wr = sel && we;
    assign bus_rd = sel && !we;
    assign cfg_wr = bus_wr && !locked;

    syscfg_keylock #(.ADDR_W(ADDR_W)) u_key (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .addr(addr),
        .wkey(wdata[15:0]), .locked(locked), .ctrl_bit(ctrl_bit)
    );

    syscfg_region #(.KIND(RGN_PLL), .BASE(PLL_BASE), .COUNT(PLL_N),
                    .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pll (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(addr), .wdata(wdata),
        .q(pll_q), .hit(pll_hit), .rd_word(pll_rd)
    );

    syscfg_region #(.KIND(RGN_RST), .BASE(RST_BASE), .COUNT(RST_N),
                    .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rst (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(addr), .wdata(wdata),
        .q(rstctl_q), .hit(rst_hit), .rd_word(rst_rd)
    );

    syscfg_region #(.KIND(RGN_DDR), .BASE(DDR_BASE), .COUNT(DDR_N),
                    .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ddr (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(addr), .wdata(wdata),
        .q(ddr_q), .hit(ddr_hit), .rd_word(ddr_rd)
    );

    syscfg_region #(.KIND(RGN_PIN), .BASE(PIN_BASE), .COUNT(PIN_N),
                    .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pin (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(addr), .wdata(wdata),
        .q(pin_q), .hit(pin_hit), .rd_word(pin_rd)
    );

    // Read value of the addressed word; key words and unmapped space give zero.
    always_comb begin
        if (addr == ADDR_W'(W_CTRL))        rd_next = DATA_W'(ctrl_bit);
        else if (addr == ADDR_W'(W_STATUS)) rd_next = DATA_W'(locked);
        else rd_next = (pll_hit ? pll_rd : '0) | (rst_hit ? rst_rd : '0)
                     | (ddr_hit ? ddr_rd : '0) | (pin_hit ? pin_rd : '0);
    end

    // Read data register: loads on a read cycle, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (bus_rd) rdata <= rd_next;
    end

    AST_KEYWORD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (addr == ADDR_W'(W_LOCK) || addr == ADDR_W'(W_UNLOCK))) |=> (rdata == '0)); // R4
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && addr == ADDR_W'(W_STATUS)) |=> (rdata == DATA_W'($past(locked)))); // R3
    AST_LOCKED_DROPS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && locked && addr > ADDR_W'(W_STATUS))
        |=> ($stable(pll_q) && $stable(rstctl_q) && $stable(ddr_q) && $stable(pin_q))); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rdata)); // R12

endmodule

// File: tb/tb_syscfg_regbank.sv
`timescale 1ns/1ps
module tb_syscfg_regbank;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel = 1'b0, we = 1'b0;
    logic [9:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         ctrl_bit, locked;
    logic [255:0]  pll_q;
    logic [767:0]  rstctl_q;
    logic [287:0]  ddr_q;
    logic [1727:0] pin_q;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    // Reference model state
    logic [31:0] mem [0:1023];
    logic m_locked, m_ctrl;
    logic [31:0] m_rdata;

    always #2.5 clk = ~clk;

    syscfg_regbank dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ctrl_bit(ctrl_bit), .locked(locked),
        .pll_q(pll_q), .rstctl_q(rstctl_q), .ddr_q(ddr_q), .pin_q(pin_q)
    );

    function automatic bit mapped(int a);
        return (a >= 'h40 && a <= 'h47) || (a >= 'h80 && a <= 'h97) ||
               (a >= 'h180 && a <= 'h188) || (a >= 'h1C0 && a <= 'h1F5);
    endfunction

    function automatic bit writable(int a);
        if (!mapped(a)) return 0;
        return !(a == 'h43 || a == 'h94 || a == 'h97 || a == 'h181);
    endfunction

    task automatic model_init();
        for (int a = 0; a < 1024; a++) mem[a] = 32'h0;
        for (int i = 0; i < 3; i++) mem['h40 + i] = 32'h0001A008;
        mem['h43] = 32'h3F;
        for (int i = 4; i < 7; i++) mem['h40 + i] = 32'h00014000;
        mem['h97] = 32'h1;
        for (int i = 0; i < 54; i++) mem['h1C0 + i] = (i >= 2 && i <= 8) ? 32'h601 : 32'h1601;
        m_locked = 1; m_ctrl = 0; m_rdata = 0;
    endtask

    task automatic model_step(input logic w, input int a, input logic [31:0] d);
        if (!w) begin
            if (a == 0)      m_rdata = {31'b0, m_ctrl};
            else if (a == 3) m_rdata = {31'b0, m_locked};
            else if (mapped(a)) m_rdata = mem[a];
            else m_rdata = 0;
        end else if (a == 0) m_ctrl = d[0];
        else if (a == 1) begin if (d[15:0] == 16'h767B) m_locked = 1; end
        else if (a == 2) begin if (d[15:0] == 16'hDF0D) m_locked = 0; end
        else if (!m_locked && writable(a)) mem[a] = d;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison of every output against the model.
    task automatic compare_all();
        logic [255:0] e_pll; logic [767:0] e_rst; logic [287:0] e_ddr; logic [1727:0] e_pin;
        for (int i = 0; i < 8; i++)  e_pll[i*32 +: 32] = mem['h40 + i];
        for (int i = 0; i < 24; i++) e_rst[i*32 +: 32] = mem['h80 + i];
        for (int i = 0; i < 9; i++)  e_ddr[i*32 +: 32] = mem['h180 + i];
        for (int i = 0; i < 54; i++) e_pin[i*32 +: 32] = mem['h1C0 + i];
        chk(rdata == m_rdata, "R12 rdata", 64'(rdata), 64'(m_rdata));
        chk(locked == m_locked, "R3 locked", 64'(locked), 64'(m_locked));
        chk(ctrl_bit == m_ctrl, "R5 ctrl_bit", 64'(ctrl_bit), 64'(m_ctrl));
        chk(pll_q == e_pll, "R7 pll_q", 64'(pll_q), 64'(e_pll));
        chk(rstctl_q == e_rst, "R8 rstctl_q", 64'(rstctl_q), 64'(e_rst));
        chk(ddr_q == e_ddr, "R9 ddr_q", 64'(ddr_q), 64'(e_ddr));
        chk(pin_q == e_pin, "R10 pin_q", 64'(pin_q), 64'(e_pin));
    endtask

    task automatic access(input logic w, input int a, input logic [31:0] d);
        sel = 1; we = w; addr = a[9:0]; wdata = d;
        @(posedge clk);
        model_step(w, a, d);
        @(negedge clk);
        sel = 0; we = 0;
        compare_all();
    endtask

    task automatic wr(input int byte_off, input logic [31:0] d);
        access(1'b1, byte_off / 4, d);
    endtask

    // Read and compare with a value stated in the requirements.
    task automatic rd(input int byte_off, input logic [31:0] exp, input string tag);
        access(1'b0, byte_off / 4, 32'h0);
        chk(rdata == exp, tag, 64'(rdata), 64'(exp));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        model_init();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare_all();
        chk(locked == 1'b1, "R3 reset locked", 64'(locked), 64'h1);
        chk(rdata == 0, "R12 reset rdata", 64'(rdata), 64'h0);

        // Reset images
        rd('h00C, 32'h1, "R3 status after reset");
        rd('h100, 32'h0001A008, "R7 pll word0 reset");
        rd('h10C, 32'h0000003F, "R7 pll status reset");
        rd('h118, 32'h00014000, "R7 pll word6 reset");
        rd('h11C, 32'h0, "R7 pll word7 reset");
        rd('h700, 32'h1601, "R10 pin0 reset");
        rd('h708, 32'h0601, "R10 pin2 reset");
        rd('h720, 32'h0601, "R10 pin8 reset");
        rd('h724, 32'h1601, "R10 pin9 reset");
        rd('h7D4, 32'h1601, "R10 pin53 reset");
        rd('h25C, 32'h1, "R8 fixed one");

        // Locked bank
        wr('h100, 32'hDEADBEEF);
        rd('h100, 32'h0001A008, "R6 locked write dropped");
        wr('h7D4, 32'h0);
        rd('h7D4, 32'h1601, "R6 locked pin write dropped");
        wr('h000, 32'hFFFFFFFF);
        rd('h000, 32'h1, "R5 ctrl set while locked");
        idle(2);
        chk(rdata == 32'h1, "R12 rdata held idle", 64'(rdata), 64'h1);

        // Unlock keys
        wr('h008, 32'h0000DF0E);
        rd('h00C, 32'h1, "R2 wrong unlock key ignored");
        wr('h004, 32'h0000DF0D);
        rd('h00C, 32'h1, "R2 unlock key at lock word ignored");
        wr('h008, 32'hABCDDF0D);
        rd('h00C, 32'h0, "R2 unlock with upper bits set");
        wr('h00C, 32'h1);
        rd('h00C, 32'h0, "R3 status write ignored");
        rd('h004, 32'h0, "R4 lock word reads zero");
        rd('h008, 32'h0, "R4 unlock word reads zero");

        // Unlocked writes
        wr('h100, 32'h12345678);
        rd('h100, 32'h12345678, "R7 pll word writable");
        wr('h10C, 32'hFFFFFFFF);
        rd('h10C, 32'h3F, "R7 pll status read-only");
        wr('h250, 32'hA5A5A5A5);
        rd('h250, 32'h0, "R8 read-only 0x250");
        wr('h25C, 32'h0);
        rd('h25C, 32'h1, "R8 0x25C stays one");
        wr('h24C, 32'h0BADF00D);
        rd('h24C, 32'h0BADF00D, "R8 neighbour writable");
        wr('h604, 32'hFFFFFFFF);
        rd('h604, 32'h0, "R9 hole ignores write");
        wr('h600, 32'h11112222);
        wr('h620, 32'h33334444);
        rd('h600, 32'h11112222, "R9 first ddr word");
        rd('h620, 32'h33334444, "R9 last ddr word");
        wr('h708, 32'hCAFE0001);
        rd('h708, 32'hCAFE0001, "R10 pin2 writable");
        wr('h300, 32'hFFFFFFFF);
        rd('h300, 32'h0, "R11 unmapped write dropped");
        rd('hFFC, 32'h0, "R11 top of window");
        rd('h0FC, 32'h0, "R11 just below pll range");
        rd('h7D8, 32'h0, "R11 just above pin range");
        wr('h000, 32'hFFFFFFFE);
        chk(rdata == 32'h0, "R12 rdata held over write", 64'(rdata), 64'h0);
        rd('h000, 32'h0, "R5 only bit0 stored");

        // Relock
        wr('h004, 32'h0000767A);
        rd('h00C, 32'h0, "R1 wrong lock key ignored");
        wr('h004, 32'hFFFF767B);
        rd('h00C, 32'h1, "R1 lock key");
        wr('h708, 32'h0);
        rd('h708, 32'hCAFE0001, "R6 relocked write dropped");
        wr('h600, 32'h0);
        rd('h600, 32'h11112222, "R6 relocked ddr write dropped");
        wr('h000, 32'h1);
        rd('h000, 32'h1, "R5 ctrl write after relock");
        idle(3);

        done = 1;
        summary();
        $finish;
    end

endmodule